// File: doc/BRIEF.md
# Return-Address Stack with Occupancy Watermark Interrupt

This block is a last-in first-out store for program counter values. A sequencer saves a return address on a call, a loop start or an interrupt entry, and restores it on the matching return. The block shows the most recent entry on `top_o` and the number of occupied entries on `level_o`. It never decides when to push or pop. That choice belongs to the sequencer.

The block also watches its own occupancy. When the fill level drops below a low mark or climbs above a high mark, it drives a single request line to the interrupt controller, where the line takes priority position 2. Software can then spill entries to memory or refill them before the stack runs out. The request is gated by an enable bit. Pushing into a full stack or popping an empty one is not performed. Each case sets a sticky error flag instead.

The default parameters give the 33-entry program counter stack, with a low mark of 3 and a high mark of 28. The same RTL, with its depth set to 8 and its own enable bit, serves as the loop stack.

Top module: `stk_hw_stack`

## Requirements
- R1: After reset, `level_o` is 0, `top_o` is 0, and both `ovf_o` and `udf_o` are 0.
- R2: A push alone on a stack that is not full stores `push_data_i` as the new top entry. It also raises `level_o` by one, visible after the next rising clock edge.
- R3: A pop alone on a non-empty stack lowers `level_o` by one. `top_o` then shows the entry that was pushed before the removed one, giving last-in first-out order.
- R4: A push alone when `level_o` equals DEPTH is ignored: `level_o` and `top_o` keep their values and `ovf_o` becomes 1.
- R5: A pop alone when the stack is empty leaves `level_o` at 0 and `top_o` at 0, and sets `udf_o` to 1. `top_o` always reads 0 while the stack is empty.
- R6: A push and a pop in the same cycle on a non-empty stack overwrite the top entry with `push_data_i` and leave `level_o` unchanged.
- R7: A push and a pop in the same cycle on an empty stack store nothing. `level_o` stays 0 and `udf_o` becomes 1.
- R8: While `irq_en_i` is 1, `irq_o` is 1 whenever `level_o` is less than LO_MARK (default 3). `irq_o` follows `level_o` combinationally, with no added register.
- R9: While `irq_en_i` is 1, `irq_o` is 1 whenever `level_o` is greater than HI_MARK (default 28). It is 0 for levels from LO_MARK to HI_MARK inclusive.
- R10: While `irq_en_i` is 0, `irq_o` is 0 at every fill level.
- R11: Once set, `ovf_o` and `udf_o` stay at 1 until reset, whatever push and pop traffic follows.
- R12: The loop-stack configuration (DEPTH 8, its own marks) fills at 8 entries. In that configuration a ninth push is ignored and sets `ovf_o`, and the watermarks apply to the 8-entry range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Save `push_data_i` on the stack |
| pop_i | input | 1 | Remove the top entry |
| push_data_i | input | DATA_W | Value to save |
| irq_en_i | input | 1 | Enable for the watermark request |
| top_o | output | DATA_W | Most recent entry, or 0 when the stack is empty |
| level_o | output | LVL_W | Number of occupied entries |
| irq_o | output | 1 | Watermark interrupt request |
| ovf_o | output | 1 | Sticky flag: a push was attempted on a full stack |
| udf_o | output | 1 | Sticky flag: a pop was attempted on an empty stack |

## Verification
A wrong fill count shows up on `level_o` and `irq_o` in the same cycle, because the request is decoded straight from the count. The same error reaches `top_o` on the next read, because the entry selected for the top is chosen by the count. A wrong write index or a lost write stays hidden until that entry becomes the top again. For that reason the bench drains every filled stack completely and compares each value it pops, so a corruption that is buried deep still appears, only many cycles later. Errors in the edge cases appear one cycle after the request, as a changed level, a changed top, or a sticky flag that fails to stay set.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    return stk_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 33,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             wr_en,
  output logic [LVL_W-1:0] wr_idx,
  output logic             ovf,
  output logic             udf
);
  logic [LVL_W-1:0] level_q, level_d;
  logic             ovf_q, ovf_d, udf_q, udf_d;
  logic             full, empty;
  stk_op_e          op;

  assign full  = (level_q == LVL_W'(DEPTH));
  assign empty = (level_q == '0);
  assign op    = decode_op(push, pop);

  always_comb begin
    level_d = level_q;
    ovf_d   = ovf_q;
    udf_d   = udf_q;
    wr_en   = 1'b0;
    wr_idx  = level_q;
    unique case (op)
      OP_PUSH: begin
        if (full) ovf_d = 1'b1;
        else begin
          wr_en   = 1'b1;
          level_d = level_q + LVL_W'(1);
        end
      end
      OP_POP: begin
        if (empty) udf_d = 1'b1;
        else       level_d = level_q - LVL_W'(1);
      end
      OP_SWAP: begin
        if (empty) udf_d = 1'b1;
        else begin
          wr_en  = 1'b1;
          wr_idx = level_q - LVL_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      ovf_q   <= ovf_d;
      udf_q   <= udf_d;
    end
  end

  assign level = level_q;
  assign ovf   = ovf_q;
  assign udf   = udf_q;
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DEPTH  = 33,
  parameter int DATA_W = 24,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  level,
  output logic [DATA_W-1:0] top
);
  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = wr_en && (wr_idx == LVL_W'(g));
  end

  // Storage is not reset: an entry is only read below the current level.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) ent_q[i] <= wr_data;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level == LVL_W'(i + 1)) top = ent_q[i];
    end
  end
endmodule

// File: rtl/stk_wmark.sv
module stk_wmark #(
  parameter int DEPTH   = 33,
  parameter int LO_MARK = 3,
  parameter int HI_MARK = 28,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level,
  input  logic             en,
  output logic             irq
);
  logic below, above;

  assign below = (level < LVL_W'(LO_MARK));
  assign above = (level > LVL_W'(HI_MARK));
  assign irq   = en && (below || above);
endmodule

// File: rtl/stk_hw_stack.sv
module stk_hw_stack #(
  parameter int DEPTH   = 33,
  parameter int DATA_W  = 24,
  parameter int LO_MARK = 3,
  parameter int HI_MARK = 28,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] top_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              udf_o
);
  logic             rst_sync_n;
  logic             wr_en;
  logic [LVL_W-1:0] wr_idx;

  stk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push   (push_i),
    .pop    (pop_i),
    .level  (level_o),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .ovf    (ovf_o),
    .udf    (udf_o)
  );

  stk_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (push_data_i),
    .level   (level_o),
    .top     (top_o)
  );

  stk_wmark #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK)) u_wm (
    .level (level_o),
    .en    (irq_en_i),
    .irq   (irq_o)
  );
endmodule

// File: rtl/stk_hw_stack_chk.sv
module stk_hw_stack_chk #(
  parameter int DEPTH   = 33,
  parameter int DATA_W  = 24,
  parameter int LO_MARK = 3,
  parameter int HI_MARK = 28,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] din,
  input logic              en,
  input logic [DATA_W-1:0] top,
  input logic [LVL_W-1:0]  level,
  input logic              irq,
  input logic              ovf,
  input logic              udf
);
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && level < LVL_W'(DEPTH) |=> level == $past(level) + LVL_W'(1) && top == $past(din)); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && level != '0 |=> level == $past(level) - LVL_W'(1)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && level == LVL_W'(DEPTH) |=> level == LVL_W'(DEPTH) && $stable(top) && ovf); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && level == '0 |=> level == '0 && udf); // R5
  AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 |-> top == '0); // R5
  AST_SWAP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && level != '0 |=> $stable(level) && top == $past(din)); // R6
  AST_SWAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && level == '0 |=> level == '0 && udf); // R7
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && level < LVL_W'(LO_MARK) |-> irq); // R8
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    en && level > LVL_W'(HI_MARK) |-> irq); // R9
  AST_IRQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    level >= LVL_W'(LO_MARK) && level <= LVL_W'(HI_MARK) |-> !irq); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R11
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udf |=> udf); // R11
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R12
endmodule

bind stk_hw_stack stk_hw_stack_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .push  (push_i),
  .pop   (pop_i),
  .din   (push_data_i),
  .en    (irq_en_i),
  .top   (top_o),
  .level (level_o),
  .irq   (irq_o),
  .ovf   (ovf_o),
  .udf   (udf_o)
);

// File: tb/stk_hw_stack_tb.sv
module stk_hw_stack_tb;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0, en = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] top;
  logic [5:0]    level;
  logic          irq, ovf, udf;

  logic          l_push = 1'b0, l_pop = 1'b0, l_en = 1'b1;
  logic [DW-1:0] l_din = '0;
  logic [DW-1:0] l_top;
  logic [3:0]    l_level;
  logic          l_irq, l_ovf, l_udf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  stk_hw_stack #(.DEPTH(33), .DATA_W(DW), .LO_MARK(3), .HI_MARK(28)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .push_data_i(din),
    .irq_en_i(en), .top_o(top), .level_o(level), .irq_o(irq), .ovf_o(ovf), .udf_o(udf)
  );

  stk_hw_stack #(.DEPTH(8), .DATA_W(DW), .LO_MARK(2), .HI_MARK(6)) u_loop (
    .clk(clk), .rst_n(rst_n), .push_i(l_push), .pop_i(l_pop), .push_data_i(l_din),
    .irq_en_i(l_en), .top_o(l_top), .level_o(l_level), .irq_o(l_irq), .ovf_o(l_ovf), .udf_o(l_udf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    push = 1'b0; pop = 1'b0; l_push = 1'b0; l_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drive one operation for one edge; return at the next falling edge.
  task automatic op(input logic p, input logic q, input logic [DW-1:0] d);
    @(negedge clk);
    push = p; pop = q; din = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic lop(input logic p, input logic q, input logic [DW-1:0] d);
    @(negedge clk);
    l_push = p; l_pop = q; l_din = d;
    @(negedge clk);
    l_push = 1'b0; l_pop = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(24'h100 + i * 3);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1", "level", 32'(level), 0);
    chk("R1", "top", 32'(top), 0);
    chk("R1", "ovf", 32'(ovf), 0);
    chk("R1", "udf", 32'(udf), 0);
    chk("R8", "irq at level 0", 32'(irq), 1);
  endtask

  task automatic t_push_pop();
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      op(1'b1, 1'b0, pat(i));
      chk("R2", "level after push", 32'(level), 32'(i));
      chk("R2", "top after push", 32'(top), 32'(pat(i)));
      chk("R8", "irq low-mark", 32'(irq), (i < 3) ? 1 : 0);
    end
    for (int i = 5; i >= 2; i--) begin
      op(1'b0, 1'b1, '0);
      chk("R3", "level after pop", 32'(level), 32'(i - 1));
      chk("R3", "top after pop", 32'(top), 32'(pat(i - 1)));
    end
  endtask

  task automatic t_swap();
    do_reset();
    op(1'b1, 1'b0, 24'hAAA);
    op(1'b1, 1'b0, 24'hBBB);
    op(1'b1, 1'b1, 24'hCCC);
    chk("R6", "level after swap", 32'(level), 2);
    chk("R6", "top after swap", 32'(top), 32'h0CCC);
    op(1'b0, 1'b1, '0);
    chk("R6", "entry below swap", 32'(top), 32'h0AAA);
  endtask

  task automatic t_fill_drain();
    do_reset();
    for (int i = 1; i <= 33; i++) begin
      op(1'b1, 1'b0, pat(i));
      if (i == 28) chk("R9", "irq at 28", 32'(irq), 0);
      if (i == 29) chk("R9", "irq at 29", 32'(irq), 1);
    end
    chk("R2", "level full", 32'(level), 33);
    op(1'b1, 1'b0, 24'hDEAD);
    chk("R4", "level after push on full", 32'(level), 33);
    chk("R4", "top after push on full", 32'(top), 32'(pat(33)));
    chk("R4", "ovf", 32'(ovf), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10", "irq masked at 33", 32'(irq), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9", "irq re-enabled at 33", 32'(irq), 1);
    for (int i = 33; i >= 1; i--) begin
      chk("R3", "drain order", 32'(top), 32'(pat(i)));
      op(1'b0, 1'b1, '0);
    end
    chk("R5", "empty level", 32'(level), 0);
    en = 1'b0;
    @(negedge clk);
    chk("R10", "irq masked at 0", 32'(irq), 0);
    en = 1'b1;
    op(1'b0, 1'b1, '0);
    chk("R5", "level after pop on empty", 32'(level), 0);
    chk("R5", "top on empty", 32'(top), 0);
    chk("R5", "udf", 32'(udf), 1);
    op(1'b1, 1'b0, 24'h123);
    op(1'b0, 1'b1, '0);
    chk("R11", "ovf held", 32'(ovf), 1);
    chk("R11", "udf held", 32'(udf), 1);
  endtask

  task automatic t_swap_empty();
    do_reset();
    op(1'b1, 1'b1, 24'h777);
    chk("R7", "level after swap on empty", 32'(level), 0);
    chk("R7", "top after swap on empty", 32'(top), 0);
    chk("R7", "udf", 32'(udf), 1);
    do_reset();
    chk("R1", "udf cleared by reset", 32'(udf), 0);
  endtask

  task automatic t_loop_cfg();
    do_reset();
    for (int i = 1; i <= 8; i++) begin
      lop(1'b1, 1'b0, pat(i));
      if (i == 6) chk("R12", "loop irq at 6", 32'(l_irq), 0);
      if (i == 7) chk("R12", "loop irq at 7", 32'(l_irq), 1);
    end
    lop(1'b1, 1'b0, 24'hBAD);
    chk("R12", "loop level full", 32'(l_level), 8);
    chk("R12", "loop top kept", 32'(l_top), 32'(pat(8)));
    chk("R12", "loop ovf", 32'(l_ovf), 1);
    chk("R12", "main stack untouched", 32'(level), 0);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_swap();
    t_fill_drain();
    t_swap_empty();
    t_loop_cfg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule